// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Writer

This block sends one nine-bit frame to a display panel's configuration port over a three-wire serial link made of a chip-select line, a serial clock and a data-out line. A host offers an 8-bit payload together with a one-bit type flag through a valid/ready handshake. The block builds the frame with the type flag on top, lowers chip select, and waits a setup interval. It then shifts the nine bits out, most significant first, and the panel samples each bit on the rising clock edge. At the end it raises chip select again, parks the data line high and pulses a completion flag.

The bit timing comes from a half-period length `HALF_CLKS`, counted in system clocks. Every phase of the frame lasts exactly one half period: the setup interval, each low phase and each high phase. A frame therefore keeps chip select low for `19 * HALF_CLKS` cycles. While chip select is high the clock and data lines idle high.

Top module: `panel_frame_tx`

## Requirements
- R1: After a synchronous active-high reset, and whenever no frame is in progress, `cs_n`, `sck` and `sdo` are 1, `req_ready` is 1 and `done` is 0.
- R2: The frame sent is `{req_is_data, req_payload}`, nine bits wide. Bit 8 is the type flag: 0 means command or address, 1 means parameter data. Bits 7..0 are the payload.
- R3: Bits leave most significant first, so the type flag is sent first and payload bit 0 is sent last.
- R4: Chip select stays low for exactly `HALF_CLKS` cycles with `sck` high before `sck` first falls.
- R5: For each bit, `sck` is low for `HALF_CLKS` cycles and then high for `HALF_CLKS` cycles. `sdo` changes only in the cycle in which `sck` falls, and holds steady while `sck` is high.
- R6: When the ninth high phase ends, `cs_n` returns to 1 and `sdo` to 1 in the same cycle, and `sck` stays 1. Chip select is low for `19 * HALF_CLKS` cycles in total.
- R7: `req_ready` is 0 from the cycle after acceptance until chip select has returned high. A request offered while a frame is in flight is ignored and does not alter the frame.
- R8: `done` is a one-cycle pulse, once per frame, in the cycle in which `cs_n` rises.
- R9: A reset asserted in the middle of a frame aborts it and returns every line to its idle level from R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_is_data | input | 1 | Type flag: 0 command, 1 parameter data |
| req_payload | input | PAYLOAD_W | Payload byte |
| done | output | 1 | One-cycle pulse at the end of a frame |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out, idles high |

## Verification
The assertions check the following rules on every cycle:
- the clock is high whenever chip select is high;
- ready is low while chip select is low;
- an accepted request lowers chip select on the next cycle;
- data is stable through every high clock phase;
- `done` occurs only when chip select rises.

Only the bench scenarios can show the rest:
- the bit values and their order on the wire;
- the exact lengths of the setup interval, the bit phases and the whole frame;
- that a request offered during a frame is ignored;
- that a reset in mid-frame aborts the frame.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HIGH  = 2'd3
  } pft_state_e;
endpackage

// File: rtl/pft_tick.sv
module pft_tick #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CLKS < 2) ? 1 : $clog2(HALF_CLKS);
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pft_shreg.sv
module pft_shreg #(
  parameter int FRAME_BITS = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_val,
  input  logic                  shift,
  output logic                  msb
);
  logic [FRAME_BITS-1:0] q;

  assign msb = q[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= {q[FRAME_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/pft_ctrl.sv
module pft_ctrl #(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic tick,
  input  logic msb,
  output logic req_ready,
  output logic done,
  output logic cs_n,
  output logic sck,
  output logic sdo,
  output logic load,
  output logic shift,
  output logic run
);
  import pft_pkg::*;

  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  pft_state_e    state_q;
  logic [BW-1:0] bit_q;

  assign run   = (state_q != ST_IDLE);
  assign load  = (state_q == ST_IDLE) && req_valid && req_ready;
  assign shift = tick && ((state_q == ST_SETUP) ||
                          ((state_q == ST_HIGH) && (bit_q != LAST_BIT)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cs_n      <= 1'b1;
      sck       <= 1'b1;
      sdo       <= 1'b1;
      req_ready <= 1'b1;
      done      <= 1'b0;
      bit_q     <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            state_q   <= ST_SETUP;
            cs_n      <= 1'b0;
            req_ready <= 1'b0;
            bit_q     <= '0;
          end
        end
        ST_SETUP: begin
          if (tick) begin
            state_q <= ST_LOW;
            sck     <= 1'b0;
            sdo     <= msb;
          end
        end
        ST_LOW: begin
          if (tick) begin
            state_q <= ST_HIGH;
            sck     <= 1'b1;
          end
        end
        default: begin
          if (tick) begin
            if (bit_q == LAST_BIT) begin
              state_q   <= ST_IDLE;
              cs_n      <= 1'b1;
              sdo       <= 1'b1;
              req_ready <= 1'b1;
              done      <= 1'b1;
            end else begin
              bit_q   <= bit_q + 1'b1;
              state_q <= ST_LOW;
              sck     <= 1'b0;
              sdo     <= msb;
            end
          end
        end
      endcase
    end
  end

  // R1: the clock idles high while chip select is high
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sck);

  // R7: the block never offers ready during a frame
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !req_ready);

  // R7: an accepted request opens a frame on the next cycle
  assert_accept_opens_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !cs_n);

  // R5: data holds through a high clock phase inside a frame
  assert_sdo_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && sck && $past(!cs_n && sck)) |-> $stable(sdo));

  // R8: done appears only as chip select rises
  assert_done_on_release_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  // R6: the data line is parked high when chip select is released
  assert_park_high_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (sdo && sck));
endmodule

// File: rtl/panel_frame_tx.sv
module panel_frame_tx #(
  parameter int PAYLOAD_W = 8,
  parameter int HALF_CLKS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_is_data,
  input  logic [PAYLOAD_W-1:0] req_payload,
  output logic                 done,
  output logic                 cs_n,
  output logic                 sck,
  output logic                 sdo
);
  localparam int FRAME_BITS = PAYLOAD_W + 1;

  logic tick, msb, load, shift, run;

  pft_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  pft_shreg #(.FRAME_BITS(FRAME_BITS)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val({req_is_data, req_payload}),
    .shift   (shift),
    .msb     (msb)
  );

  pft_ctrl #(.FRAME_BITS(FRAME_BITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .tick     (tick),
    .msb      (msb),
    .req_ready(req_ready),
    .done     (done),
    .cs_n     (cs_n),
    .sck      (sck),
    .sdo      (sdo),
    .load     (load),
    .shift    (shift),
    .run      (run)
  );
endmodule

// File: tb/tb_panel_frame_tx.sv
module tb_panel_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int NVEC = 6;
  // {is_data, payload, expected 9-bit frame on the wire}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 8'h01, 9'h001},
    {1'b0, 8'h11, 9'h011},
    {1'b1, 8'h04, 9'h104},
    {1'b1, 8'hA5, 9'h1A5},
    {1'b0, 8'hFF, 9'h0FF},
    {1'b1, 8'h00, 9'h100}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_is_data = 1'b0;
  logic [7:0] req_payload = 8'h00;
  logic req_ready, done, cs_n, sck, sdo;
  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_frame_tx #(.PAYLOAD_W(8), .HALF_CLKS(HALF)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_payload(req_payload), .done(done),
    .cs_n(cs_n), .sck(sck), .sdo(sdo)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(cs_n == 1'b1, req, cs_n, 1);
    chk(sck == 1'b1, req, sck, 1);
    chk(sdo == 1'b1, req, sdo, 1);
    chk(req_ready == 1'b1, req, req_ready, 1);
    chk(done == 1'b0, req, done, 0);
  endtask

  task automatic run_frame(input bit isd, input logic [7:0] pl,
                           input logic [8:0] expf, input bit poke);
    int low_cnt = 0;
    int sck_low = 0;
    int first_low = -1;
    int nbits = 0;
    int ready_bad = 0;
    int done_bad = 0;
    int stable_bad = 0;
    bit prev_sck = 1'b1;
    bit prev_sdo = 1'b1;
    bit saw_done = 1'b0;
    logic [8:0] cap = '0;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = isd; req_payload = pl;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      if (cs_n) begin
        saw_done = done;
        break;
      end
      if (!sck && first_low < 0) first_low = low_cnt;
      if (!sck) sck_low++;
      if (!prev_sck && sck) begin
        cap = {cap[7:0], sdo};
        nbits++;
      end
      if (sck && prev_sck && first_low >= 0 && sdo != prev_sdo) stable_bad++;
      if (req_ready) ready_bad++;
      if (done) done_bad++;
      prev_sck = sck; prev_sdo = sdo;
      low_cnt++;
      if (poke && low_cnt == 5) begin
        req_valid = 1'b1; req_is_data = ~isd; req_payload = ~pl;
      end
      if (poke && low_cnt == 9) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(cap == expf, "R2 frame content", cap, expf);
    chk(nbits == 9, "R3 bit count msb-first", nbits, 9);
    chk(first_low == HALF, "R4 setup interval", first_low, HALF);
    chk(sck_low == 9*HALF, "R5 low phase total", sck_low, 9*HALF);
    chk(stable_bad == 0, "R5 sdo stable while sck high", stable_bad, 0);
    chk(low_cnt == 19*HALF, "R6 cs low length", low_cnt, 19*HALF);
    chk(sdo == 1'b1 && sck == 1'b1, "R6 park levels", {sck, sdo}, 3);
    chk(ready_bad == 0, "R7 ready low while busy", ready_bad, 0);
    chk(saw_done && done_bad == 0, "R8 done at release", saw_done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    check_idle("R1 idle after frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 idle after reset release");

    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][17], VEC[i][16:9], VEC[i][8:0], 1'b0);
    end

    // R7: a request offered during a frame is ignored
    run_frame(1'b0, 8'h3A, 9'h03A, 1'b1);

    // R9: reset in the middle of a frame aborts it
    @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b1; req_payload = 8'hC3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(cs_n == 1'b0, "R9 frame in flight", cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R9 abort to idle");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R9 idle after abort");
    run_frame(1'b1, 8'h5C, 9'h15C, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule